// File: doc/BRIEF.md
# Interrupt Status and Clear Controller

This block gathers twelve event sources from a serial bus controller into one status word and produces one interrupt request. Ten of the sources are sticky: a one-cycle pulse on an event input sets a status bit, and the bit stays set until software clears it. The other two sources, receive-full and transmit-empty, follow FIFO threshold levels directly and are never stored. A writable mask selects which status bits can raise the interrupt. Software reads the masked view of the status, the unmasked view, the mask and a captured abort-cause word through a small register port.

Clearing works by reading, not by writing. Each sticky source has its own clear address, and a read there drops only that source's bit. One more clear address drops every sticky bit at once. The abort-cause word gathers the reason bits supplied alongside each transmit-abort pulse. It is wiped whenever the transmit-abort bit is cleared, by either the per-source clear or the combined clear. If an event pulse lands in the same cycle as a clear read for its source, the event wins, so no event is lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the sticky status bits, the mask and the abort-cause word are all zero, and `irq_o` is low.
- R2: A pulse on `evt_pulse_i[b]` for a sticky source b sets status bit b at the next clock edge. The bit then stays set until it is cleared. The sticky sources are bits 0 rx underflow, 1 rx overflow, 3 tx overflow, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen and 11 general call.
- R3: Status bit 2 equals `rx_full_lvl_i` and status bit 4 equals `tx_empty_lvl_i` in the same cycle. Clear reads do not affect them, and `evt_pulse_i[2]` and `evt_pulse_i[4]` are ignored.
- R4: A write at offset 0x30 loads the 12-bit mask from the next edge, and a read at 0x30 returns it. A read at 0x2C returns the status ANDed with the mask, and a read at 0x34 returns the unmasked status.
- R5: `irq_o` is high exactly when at least one status bit is set and enabled by the mask.
- R6: A read at 0x44 + 4*k clears exactly one sticky bit, taking k = 0..9 in ascending bit order over the sticky sources: 0x44 bit 0, 0x48 bit 1, 0x4C bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5C bit 8, 0x60 bit 9, 0x64 bit 10, 0x68 bit 11.
- R7: A read at 0x40 clears every sticky bit and the abort-cause word.
- R8: A read at 0x54 clears the transmit-abort bit and also sets the abort-cause word to zero.
- R9: If a pulse for a sticky source arrives in the same cycle as a clear read for that source, the bit remains set. The abort-cause word then holds only the reason bits supplied in that cycle.
- R10: On each transmit-abort pulse, `abort_src_i` is ORed into the abort-cause word, which reads back at 0x80.
- R11: Reads of any clear address, or of any unmapped address, return zero. Writes to any address other than 0x30 change nothing.
- R12: Only read strobes clear. A write strobe at a clear address leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| rd_i | input | 1 | Read strobe; clear addresses act on it |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 12 | Write data (mask value) |
| rdata_o | output | 32 | Read data for `addr_i`, valid in the same cycle |
| evt_pulse_i | input | 12 | One-cycle event pulses, indexed by status bit |
| rx_full_lvl_i | input | 1 | Receive FIFO at or above threshold |
| tx_empty_lvl_i | input | 1 | Transmit FIFO at or below threshold |
| abort_src_i | input | 13 | Abort reason bits sampled with the abort pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Every stored bit can be seen at the ports within one cycle. A lost set or a spurious clear shows up in the next unmasked status read, and with the mask open it also shows up at once on `irq_o`. The bench therefore compares `rdata_o` and `irq_o` against its model on every clock, and reads back the unmasked status after each clear, so a clear that hits the wrong slot is caught one cycle after the read. The abort-cause word is read after accumulation, after an isolated clear and after a collision, because a stale cause value stays hidden until offset 0x80 is read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 12;
  localparam int NUM_CLR = 10;

  localparam int B_RX_FULL  = 2;
  localparam int B_TX_EMPTY = 4;
  localparam int B_TX_ABORT = 6;

  localparam logic [NUM_SRC-1:0] STICKY_MASK = 12'hFEB;

  localparam int OFS_MASKED  = 'h2C;
  localparam int OFS_MASK    = 'h30;
  localparam int OFS_RAW     = 'h34;
  localparam int OFS_CLR_ALL = 'h40;
  localparam int OFS_CLR_0   = 'h44;
  localparam int OFS_CAUSE   = 'h80;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_MASKED,
    RSEL_MASK,
    RSEL_RAW,
    RSEL_CAUSE
  } rsel_e;

  // clear slot k -> status bit (skips the two level-driven bits)
  function automatic int slot_bit(input int k);
    if (k < 2) return k;
    else if (k == 2) return 3;
    else return k + 2;
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               mask_we_o,
  output rsel_e              rsel_o
);
  localparam logic [ADDR_W-1:0] A_MASKED  = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RAW     = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_CLR_ALL = ADDR_W'(OFS_CLR_ALL);
  localparam logic [ADDR_W-1:0] A_CAUSE   = ADDR_W'(OFS_CAUSE);

  logic [NUM_CLR-1:0] slot_hit;
  logic               all_hit;

  for (genvar k = 0; k < NUM_CLR; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(OFS_CLR_0 + 4 * k);
    assign slot_hit[k] = rd_i && (addr_i == A_SLOT);
  end

  assign all_hit = rd_i && (addr_i == A_CLR_ALL);

  always_comb begin
    clr_o = '0;
    for (int k = 0; k < NUM_CLR; k++) begin
      if (slot_hit[k]) clr_o[slot_bit(k)] = 1'b1;
    end
    if (all_hit) clr_o = clr_o | STICKY_MASK;
  end

  assign mask_we_o = wr_i && (addr_i == A_MASK);

  always_comb begin
    unique case (addr_i)
      A_MASKED: rsel_o = RSEL_MASKED;
      A_MASK:   rsel_o = RSEL_MASK;
      A_RAW:    rsel_o = RSEL_RAW;
      A_CAUSE:  rsel_o = RSEL_CAUSE;
      default:  rsel_o = RSEL_NONE;
    endcase
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
  import irq_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] STICKY = STICKY_MASK
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  output logic [NUM_SRC-1:0] raw_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      logic q;
      logic unused_lvl;
      assign unused_lvl = lvl_i[i];
      // set wins over a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign raw_o[i] = q;
    end else begin : g_level
      logic unused_ctl;
      assign unused_ctl = set_i[i] ^ clr_i[i];
      assign raw_o[i] = lvl_i[i];
    end
  end
endmodule

// File: rtl/irq_abort_cause.sv
module irq_abort_cause #(
  parameter int CAUSE_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               abort_i,
  input  logic               clr_i,
  input  logic [CAUSE_W-1:0] src_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d, fresh;

  assign fresh = abort_i ? src_i : '0;

  always_comb begin
    if (clr_i) cause_d = fresh;
    else       cause_d = cause_q | fresh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] evt_pulse_i,
  input  logic               rx_full_lvl_i,
  input  logic               tx_empty_lvl_i,
  input  logic [CAUSE_W-1:0] abort_src_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] clr_vec;
  logic               mask_we;
  rsel_e              rsel;
  logic [NUM_SRC-1:0] lvl_vec;
  logic [NUM_SRC-1:0] raw_stat;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] masked_stat;
  logic [CAUSE_W-1:0] cause_q;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .clr_o     (clr_vec),
    .mask_we_o (mask_we),
    .rsel_o    (rsel)
  );

  always_comb begin
    lvl_vec             = '0;
    lvl_vec[B_RX_FULL]  = rx_full_lvl_i;
    lvl_vec[B_TX_EMPTY] = tx_empty_lvl_i;
  end

  irq_sticky_bank #(.STICKY(STICKY_MASK)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_pulse_i),
    .clr_i  (clr_vec),
    .lvl_i  (lvl_vec),
    .raw_o  (raw_stat)
  );

  irq_abort_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (evt_pulse_i[B_TX_ABORT]),
    .clr_i   (clr_vec[B_TX_ABORT]),
    .src_i   (abort_src_i),
    .cause_o (cause_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_we) mask_q <= wdata_i;
  end

  assign masked_stat = raw_stat & mask_q;
  assign irq_o       = |masked_stat;

  always_comb begin
    rdata_o = '0;
    unique case (rsel)
      RSEL_MASKED: rdata_o = DATA_W'(masked_stat);
      RSEL_MASK:   rdata_o = DATA_W'(mask_q);
      RSEL_RAW:    rdata_o = DATA_W'(raw_stat);
      RSEL_CAUSE:  rdata_o = DATA_W'(cause_q);
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_sva.sv
module irq_status_sva
  import irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 13
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               rd_i,
  input logic [NUM_SRC-1:0] evt_pulse_i,
  input logic               rx_full_lvl_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] raw_stat,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [CAUSE_W-1:0] cause_q
);
  logic [NUM_SRC-1:0] sticky;
  logic               clr_addr;
  assign sticky   = raw_stat & STICKY_MASK;
  assign clr_addr = (addr_i >= ADDR_W'(OFS_CLR_ALL)) && (addr_i <= ADDR_W'(OFS_CLR_0 + 4 * (NUM_CLR - 1)));

  AST_PULSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky & $past(evt_pulse_i & STICKY_MASK)) == $past(evt_pulse_i & STICKY_MASK))); // R2 R9

  AST_NO_SET_WITHOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky & ~$past(sticky) & ~$past(evt_pulse_i)) == '0)); // R2

  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sticky) & ~sticky) == '0) || $past(rd_i))); // R12

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0)); // R5

  AST_LEVEL_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_lvl_i && mask_q[B_RX_FULL]) |-> irq_o); // R3

  AST_CAUSE_NEEDS_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q != '0) |-> raw_stat[B_TX_ABORT]); // R8

  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && clr_addr) |-> (rdata_o == '0)); // R11
endmodule

bind irq_status_ctrl irq_status_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)
) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .rd_i          (rd_i),
  .evt_pulse_i   (evt_pulse_i),
  .rx_full_lvl_i (rx_full_lvl_i),
  .rdata_o       (rdata_o),
  .irq_o         (irq_o),
  .raw_stat      (raw_stat),
  .mask_q        (mask_q),
  .cause_q       (cause_q)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] pulse = '0;
  logic        rxl = 1'b0;
  logic        txl = 1'b0;
  logic [12:0] asrc = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  logic [11:0] m_sticky = '0;
  logic [11:0] m_mask = '0;
  logic [12:0] m_cause = '0;
  int          clr_map[$] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};

  always #5 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .addr_i         (addr),
    .rd_i           (rd),
    .wr_i           (wr),
    .wdata_i        (wdata),
    .rdata_o        (rdata),
    .evt_pulse_i    (pulse),
    .rx_full_lvl_i  (rxl),
    .tx_empty_lvl_i (txl),
    .abort_src_i    (asrc),
    .irq_o          (irq)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] m_raw();
    logic [11:0] r;
    r = m_sticky & 12'hFEB;
    r[2] = rxl;
    r[4] = txl;
    return r;
  endfunction

  // one clock: drive after the falling edge, compare, then advance the model at the rising edge
  task automatic step(input string tag, input logic [7:0] a, input logic r, input logic w,
                      input logic [11:0] wd, input logic [11:0] p, input logic [12:0] s);
    logic [31:0] exp_rd;
    logic [11:0] clr, nxt_sticky, nxt_mask;
    logic [12:0] nxt_cause, fresh;
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = wd; pulse = p; asrc = s;
    #2;
    case (a)
      8'h2C:   exp_rd = 32'(m_raw() & m_mask);
      8'h30:   exp_rd = 32'(m_mask);
      8'h34:   exp_rd = 32'(m_raw());
      8'h80:   exp_rd = 32'(m_cause);
      default: exp_rd = 32'h0;
    endcase
    check(tag, "rdata", rdata, exp_rd);
    check("R5", "irq", 32'(irq), 32'(|(m_raw() & m_mask)));
    clr = '0;
    if (r) begin
      if (a == 8'h40) clr = 12'hFEB;
      for (int k = 0; k < 10; k++)
        if (a == 8'(8'h44 + 4 * k)) clr[clr_map[k]] = 1'b1;
    end
    nxt_sticky = ((m_sticky & ~clr) | p) & 12'hFEB;
    fresh = p[6] ? s : 13'h0;
    nxt_cause = clr[6] ? fresh : (m_cause | fresh);
    nxt_mask = (w && a == 8'h30) ? wd : m_mask;
    @(posedge clk);
    m_sticky = nxt_sticky;
    m_cause = nxt_cause;
    m_mask = nxt_mask;
  endtask

  task automatic rd_at(input string tag, input logic [7:0] a);
    step(tag, a, 1'b1, 1'b0, '0, '0, '0);
  endtask

  task automatic idle(input string tag);
    step(tag, 8'h00, 1'b0, 1'b0, '0, '0, '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state seen at the ports while reset is held
    addr = 8'h34; #1; check("R1", "raw", rdata, 32'h0);
    addr = 8'h30; #1; check("R1", "mask", rdata, 32'h0);
    addr = 8'h80; #1; check("R1", "cause", rdata, 32'h0);
    check("R1", "irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    idle("R1");

    // R4: mask write, readback
    step("R4", 8'h30, 1'b0, 1'b1, 12'hFFF, '0, '0);
    rd_at("R4", 8'h30);

    // R2: each sticky source set by its own pulse, held afterwards
    for (int k = 0; k < 10; k++) begin
      step("R2", 8'h34, 1'b0, 1'b0, '0, 12'(1 << clr_map[k]), '0);
      rd_at("R2", 8'h34);
    end
    rd_at("R4", 8'h2C);

    // R6: per-source clears, raw read after each
    for (int k = 0; k < 10; k++) begin
      rd_at("R6", 8'(8'h44 + 4 * k));
      rd_at("R6", 8'h34);
    end

    // R3: level bits follow inputs and ignore pulses/clears
    rxl = 1'b1; txl = 1'b1;
    step("R3", 8'h34, 1'b0, 1'b0, '0, 12'h014, '0);
    rd_at("R3", 8'h40);
    rd_at("R3", 8'h34);
    rxl = 1'b0;
    rd_at("R3", 8'h34);
    txl = 1'b0;

    // R10, R8: abort cause accumulates, cleared with the abort bit
    step("R10", 8'h80, 1'b0, 1'b0, '0, 12'h040, 13'h0005);
    step("R10", 8'h80, 1'b0, 1'b0, '0, 12'h040, 13'h1000);
    rd_at("R10", 8'h80);
    rd_at("R8", 8'h54);
    rd_at("R8", 8'h80);
    rd_at("R8", 8'h34);

    // R9: collision of pulse and clear
    step("R9", 8'h60, 1'b1, 1'b0, '0, 12'h200, '0);
    rd_at("R9", 8'h34);
    step("R9", 8'h80, 1'b0, 1'b0, '0, 12'h040, 13'h0003);
    step("R9", 8'h54, 1'b1, 1'b0, '0, 12'h040, 13'h0100);
    rd_at("R9", 8'h80);

    // R7: combined clear
    step("R7", 8'h34, 1'b0, 1'b0, '0, 12'hFEB, 13'h0010);
    rd_at("R7", 8'h40);
    rd_at("R7", 8'h34);
    rd_at("R7", 8'h80);

    // R12, R11: writes at clear or other addresses do nothing
    step("R12", 8'h34, 1'b0, 1'b0, '0, 12'h8A1, '0);
    step("R12", 8'h40, 1'b0, 1'b1, 12'h000, '0, '0);
    step("R12", 8'h4C, 1'b0, 1'b1, 12'h000, '0, '0);
    rd_at("R12", 8'h34);
    step("R11", 8'h2C, 1'b0, 1'b1, 12'h000, '0, '0);
    step("R11", 8'h34, 1'b0, 1'b1, 12'h000, '0, '0);
    rd_at("R11", 8'h30);
    rd_at("R11", 8'h3C);
    rd_at("R11", 8'h48);

    // R5: mask gating of irq
    step("R5", 8'h30, 1'b0, 1'b1, 12'h002, '0, '0);
    idle("R5");
    step("R5", 8'h30, 1'b0, 1'b1, 12'h020, '0, '0);
    idle("R5");
    rd_at("R5", 8'h40);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0: a = 8'h2C; 1: a = 8'h30; 2: a = 8'h34; 3: a = 8'h80; 4: a = 8'h40;
        default: a = 8'(8'h44 + 4 * $urandom_range(0, 9));
      endcase
      rxl = 1'($urandom_range(0, 1));
      txl = 1'($urandom_range(0, 1));
      step("R6", a, 1'($urandom_range(0, 1)), (sel == 1) && ($urandom_range(0, 3) == 0),
           12'($urandom), 12'($urandom) & 12'($urandom), 13'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule